// File: doc/BRIEF.md
# Key-Protected Watchdog Timer

This block is a memory-mapped watchdog timer. Software loads a 16-bit up-counter and picks a tick rate. It then enables counting. The counter wraps past its top value when software fails to reload it in time. At that wrap the block raises a one-cycle reset request and latches a sticky overflow flag. All three registers resist stray stores: a store lands only when the upper bits of the write data carry that register's key. Any other store is dropped without a trace.

An accepted store sets a busy flag. The flag stays up for two prescaled ticks, which models the time the update needs to reach the counting logic. Software polls the flag before enabling the timer. Counter reloads are taken only while the timer is stopped.

The register port is a plain single-cycle strobe with a combinational read path. Every strobe is taken in the cycle it appears, so this port has no valid/ready pair and never applies back-pressure. The reset request is a plain status pulse.

Top module: `keyed_wdt`

## Requirements
- R1: A store to address 0 loads the counter from data bits 15:0, but only when data bits 31:16 equal 0x5A5A and the timer is stopped.
- R2: A store to address 1 (control A) or address 2 (control B) lands only when data bits 31:8 equal 0xA5A5A5. Control B keeps data bits 7:0 as plain storage.
- R3: A store with the wrong key, or a store to address 3, changes no register and does not set the busy flag.
- R4: Control A bit 7 enables the timer. While it is set, the counter goes up by one on each prescaled tick. While it is clear, the counter holds its value.
- R5: Control A bits 2:0 select the tick divider. Codes 0 to 7 give division by 1, 4, 16, 32, 64, 128, 1024 and 4096. An accepted store restarts the divider phase, so the first tick comes exactly one divide period after the store.
- R6: When the counter wraps from 0xFFFF to 0 while enabled, `rst_req` is high for exactly one cycle, starting the cycle after the wrapping edge. At the same edge, control A bit 5 (overflow) becomes 1. A load of 65536−N therefore overflows on the N-th tick.
- R7: The overflow flag is sticky. A keyed store with bit 5 = 0 clears it, and a store with bit 5 = 1 leaves it unchanged. If a clearing store lands on the same edge as a new overflow, the flag ends up set.
- R8: Control A bit 6 is a read-only busy flag. It is set by every accepted store and clears by itself after two prescaled ticks, which is 2×divider cycles after the store.
- R9: A keyed counter store made while the timer is enabled is ignored.
- R10: Reads return the zero-extended count at address 0, control A at address 1 (bits 4:3 read 0), control B at address 2 and zero at address 3.
- R11: After reset, the counter, both control registers, the busy flag and `rst_req` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Store strobe, taken in the cycle it is high |
| reg_addr | input | 2 | Register address for reads and stores |
| reg_wdata | input | 32 | Store data: key in the upper bits, payload in the lower bits |
| reg_rdata | output | 32 | Combinational read data for `reg_addr` |
| rst_req | output | 1 | One-cycle reset request on overflow |

## Verification
Two events can fall on the same clock edge: the counter wrapping, and a software store that clears the overflow flag. The bench loads 0xFFFE at divider 1 and enables the timer. It waits one cycle, then times a control store with bit 5 = 0 so that it lands exactly on the wrapping edge. It then checks that `rst_req` pulses and that the overflow flag reads 1. A later clearing store must then read 0.

// File: rtl/keyed_wdt_pkg.sv
package keyed_wdt_pkg;
  localparam int ADDR_W  = 2;
  localparam int DATA_W  = 32;
  localparam int CNT_W   = 16;
  localparam int BYTE_W  = 8;
  localparam int CKS_W   = 3;
  localparam int PRE_W   = 12;

  localparam logic [ADDR_W-1:0] ADR_COUNT = 2'd0;
  localparam logic [ADDR_W-1:0] ADR_CTLA  = 2'd1;
  localparam logic [ADDR_W-1:0] ADR_CTLB  = 2'd2;

  localparam logic [DATA_W-CNT_W-1:0]  KEY_COUNT = 16'h5A5A;
  localparam logic [DATA_W-BYTE_W-1:0] KEY_CTL   = 24'hA5A5A5;

  localparam int BIT_RUN  = 7;
  localparam int BIT_BUSY = 6;
  localparam int BIT_OVF  = 5;

  // low-bit mask of the divider phase counter for each select code
  function automatic logic [PRE_W-1:0] div_mask(input logic [CKS_W-1:0] sel);
    logic [PRE_W-1:0] m;
    case (sel)
      3'd0:    m = 12'h000;
      3'd1:    m = 12'h003;
      3'd2:    m = 12'h00F;
      3'd3:    m = 12'h01F;
      3'd4:    m = 12'h03F;
      3'd5:    m = 12'h07F;
      3'd6:    m = 12'h3FF;
      default: m = 12'hFFF;
    endcase
    return m;
  endfunction
endpackage

// File: rtl/keyed_wdt_keycheck.sv
module keyed_wdt_keycheck
  import keyed_wdt_pkg::*;
(
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              running,
  output logic              count_we,
  output logic              ctla_we,
  output logic              ctlb_we,
  output logic              any_we
);
  localparam int LOW_CNT = CNT_W;
  localparam int LOW_CTL = BYTE_W;

  logic count_key_ok;
  logic ctl_key_ok;

  always_comb begin
    count_key_ok = (reg_wdata[DATA_W-1:LOW_CNT] == KEY_COUNT);
    ctl_key_ok   = (reg_wdata[DATA_W-1:LOW_CTL] == KEY_CTL);
    count_we = reg_wr && (reg_addr == ADR_COUNT) && count_key_ok && !running;
    ctla_we  = reg_wr && (reg_addr == ADR_CTLA)  && ctl_key_ok;
    ctlb_we  = reg_wr && (reg_addr == ADR_CTLB)  && ctl_key_ok;
    any_we   = count_we || ctla_we || ctlb_we;
  end
endmodule

// File: rtl/keyed_wdt_prescaler.sv
module keyed_wdt_prescaler
  import keyed_wdt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [CKS_W-1:0] sel,
  output logic             tick
);
  logic [PRE_W-1:0] phase_q;
  logic [PRE_W-1:0] mask;

  always_comb begin
    mask = div_mask(sel);
    tick = ((phase_q & mask) == mask);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || restart) phase_q <= '0;
    else                   phase_q <= phase_q + 1'b1;
  end
endmodule

// File: rtl/keyed_wdt_counter.sv
module keyed_wdt_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         run,
  input  logic         tick,
  output logic [W-1:0] count,
  output logic         wrap
);
  logic [W-1:0] count_q;

  always_comb begin
    count = count_q;
    wrap  = run && tick && (count_q == {W{1'b1}});
  end

  always_ff @(posedge clk) begin
    if (!rst_n)           count_q <= '0;
    else if (load)        count_q <= load_val;
    else if (run && tick) count_q <= count_q + 1'b1;
  end
endmodule

// File: rtl/keyed_wdt_busy.sv
module keyed_wdt_busy #(
  parameter int TICKS = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic tick,
  output logic busy
);
  localparam int BW = $clog2(TICKS + 1);
  localparam logic [BW-1:0] INIT = BW'(TICKS);

  logic [BW-1:0] left_q;

  assign busy = (left_q != '0);

  always_ff @(posedge clk) begin
    if (!rst_n)             left_q <= '0;
    else if (start)         left_q <= INIT;
    else if (tick && busy)  left_q <= left_q - 1'b1;
  end
endmodule

// File: rtl/keyed_wdt.sv
module keyed_wdt
  import keyed_wdt_pkg::*;
#(
  parameter int BUSY_TICKS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              rst_req
);
  logic             count_we, ctla_we, ctlb_we, any_we;
  logic             run_q, ovf_q, busy, tick, wrap;
  logic [CKS_W-1:0] sel_q;
  logic [BYTE_W-1:0] ctlb_q;
  logic [CNT_W-1:0] count;
  logic             req_q;

  keyed_wdt_keycheck u_key (
    .reg_wr   (reg_wr),
    .reg_addr (reg_addr),
    .reg_wdata(reg_wdata),
    .running  (run_q),
    .count_we (count_we),
    .ctla_we  (ctla_we),
    .ctlb_we  (ctlb_we),
    .any_we   (any_we)
  );

  keyed_wdt_prescaler u_pre (
    .clk    (clk),
    .rst_n  (rst_n),
    .restart(any_we),
    .sel    (sel_q),
    .tick   (tick)
  );

  keyed_wdt_counter #(.W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (count_we),
    .load_val(reg_wdata[CNT_W-1:0]),
    .run     (run_q),
    .tick    (tick),
    .count   (count),
    .wrap    (wrap)
  );

  keyed_wdt_busy #(.TICKS(BUSY_TICKS)) u_busy (
    .clk  (clk),
    .rst_n(rst_n),
    .start(any_we),
    .tick (tick),
    .busy (busy)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      sel_q  <= '0;
      ovf_q  <= 1'b0;
      ctlb_q <= '0;
      req_q  <= 1'b0;
    end else begin
      req_q <= wrap;
      if (ctla_we) begin
        run_q <= reg_wdata[BIT_RUN];
        sel_q <= reg_wdata[CKS_W-1:0];
      end
      // hardware set has priority over a software clear
      if (wrap)         ovf_q <= 1'b1;
      else if (ctla_we) ovf_q <= ovf_q & reg_wdata[BIT_OVF];
      if (ctlb_we) ctlb_q <= reg_wdata[BYTE_W-1:0];
    end
  end

  assign rst_req = req_q;

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      ADR_COUNT: reg_rdata[CNT_W-1:0] = count;
      ADR_CTLA: begin
        reg_rdata[BIT_RUN]   = run_q;
        reg_rdata[BIT_BUSY]  = busy;
        reg_rdata[BIT_OVF]   = ovf_q;
        reg_rdata[CKS_W-1:0] = sel_q;
      end
      ADR_CTLB:  reg_rdata[BYTE_W-1:0] = ctlb_q;
      default:   reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/keyed_wdt_chk.sv
module keyed_wdt_chk
  import keyed_wdt_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic              rst_req,
  input logic              run,
  input logic              ovf,
  input logic              busy,
  input logic              tick,
  input logic [CNT_W-1:0]  count
);
  logic cnt_store, ctla_store, ctla_keyed;
  assign cnt_store  = reg_wr && (reg_addr == ADR_COUNT);
  assign ctla_store = reg_wr && (reg_addr == ADR_CTLA);
  assign ctla_keyed = ctla_store && (reg_wdata[DATA_W-1:BYTE_W] == KEY_CTL);

  a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req);

  a_r6_flag_with_req: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> ovf);

  a_r3_bad_count_key: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_store && reg_wdata[DATA_W-1:CNT_W] != KEY_COUNT && !run) |=> $stable(count));

  a_r9_no_load_running: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_store && run && !tick) |=> $stable(count));

  a_r4_hold_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !cnt_store) |=> $stable(count));

  a_r8_busy_on_store: assert property (@(posedge clk) disable iff (!rst_n)
    ctla_keyed |=> busy);

  a_r7_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !ctla_store) |=> ovf);
endmodule

bind keyed_wdt keyed_wdt_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .reg_wr   (reg_wr),
  .reg_addr (reg_addr),
  .reg_wdata(reg_wdata),
  .rst_req  (rst_req),
  .run      (run_q),
  .ovf      (ovf_q),
  .busy     (busy),
  .tick     (tick),
  .count    (count)
);

// File: tb/keyed_wdt_tb.sv
`timescale 1ns/1ps
module keyed_wdt_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        rst_req;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  keyed_wdt u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rst_req(rst_req)
  );

  // vector: address, store data, expected read-back of that address
  localparam int NV = 10;
  localparam logic [65:0] VEC [NV] = '{
    {2'd0, 32'h5A5A1234, 32'h00001234},  // R1 keyed load
    {2'd0, 32'h5A5B9999, 32'h00001234},  // R3 wrong key
    {2'd1, 32'hA5A5A51B, 32'h00000043},  // R2 R10 sel 3, bits 4:3 dropped, busy
    {2'd1, 32'hA5A5A407, 32'h00000003},  // R3 wrong key, no busy
    {2'd2, 32'hA5A5A5C3, 32'h000000C3},  // R2 control B
    {2'd2, 32'h00A5A511, 32'h000000C3},  // R3
    {2'd0, 32'hA5A5A5FF, 32'h00001234},  // R3 control key on counter
    {2'd1, 32'h5A5A0006, 32'h00000003},  // R3 counter key on control
    {2'd3, 32'hA5A5A5FF, 32'h00000000},  // R3 R10 unmapped
    {2'd1, 32'hA5A5A524, 32'h00000044}   // R7 writing 1 to flag keeps it 0
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  // called at a negedge; store lands on the next edge, returns after it
  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] v);
    reg_addr = a;
    #0.2;
    v = reg_rdata;
  endtask

  initial begin
    #(5.0 * 190000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, v2;
    step(4);
    // R11 reset state
    rd(2'd0, v); check("R11 count", v, 32'h0);
    rd(2'd1, v); check("R11 ctla", v, 32'h0);
    rd(2'd2, v); check("R11 ctlb", v, 32'h0);
    check("R11 rst_req", {31'd0, rst_req}, 32'h0);
    rst_n = 1'b1;
    step(1);

    for (int i = 0; i < NV; i++) begin
      step(150);
      wr(VEC[i][65:64], VEC[i][63:32]);
      rd(VEC[i][65:64], v);
      check($sformatf("R1/R2/R3/R10 vec%0d", i), v, VEC[i][31:0]);
    end

    // R8 R5: busy spans 2 ticks at divide-by-4 = 8 cycles
    step(300);
    wr(2'd1, 32'hA5A5A501);
    step(7); rd(2'd1, v); check("R8 busy held", {31'd0, v[6]}, 32'h1);
    step(1); rd(2'd1, v); check("R8 busy cleared", {31'd0, v[6]}, 32'h0);

    // R6 R4: load 65536-3 at divide-by-1
    wr(2'd1, 32'hA5A5A500);
    wr(2'd0, 32'h5A5AFFFD);
    wr(2'd1, 32'hA5A5A580);
    step(2); rd(2'd0, v); check("R4 count step", v, 32'h0000FFFF);
    check("R6 no early req", {31'd0, rst_req}, 32'h0);
    step(1); check("R6 req pulse", {31'd0, rst_req}, 32'h1);
    rd(2'd0, v); check("R6 wrapped", v, 32'h0);
    rd(2'd1, v); check("R6 flag set", {31'd0, v[5]}, 32'h1);
    step(1); check("R6 req one cycle", {31'd0, rst_req}, 32'h0);

    // R7 clear by writing 0; R5 divide-by-4 timing, 2 ticks
    wr(2'd1, 32'hA5A5A500);
    rd(2'd1, v); check("R7 flag cleared", {31'd0, v[5]}, 32'h0);
    wr(2'd0, 32'h5A5AFFFE);
    wr(2'd1, 32'hA5A5A581);
    step(7); rd(2'd0, v); check("R5 one tick after 4", v, 32'h0000FFFF);
    check("R5 no req yet", {31'd0, rst_req}, 32'h0);
    step(1); check("R5 req at 8", {31'd0, rst_req}, 32'h1);

    // R9 counter store ignored while running (slow divider keeps count still)
    wr(2'd1, 32'hA5A5A5A7);
    rd(2'd1, v); check("R7 write 1 keeps flag", {31'd0, v[5]}, 32'h1);
    rd(2'd0, v);
    wr(2'd0, 32'h5A5A1111);
    rd(2'd0, v2); check("R9 load ignored", v2, v);

    // R4 hold while stopped
    wr(2'd1, 32'hA5A5A527);
    rd(2'd0, v);
    step(20);
    rd(2'd0, v2); check("R4 hold", v2, v);

    // R7 clear and overflow on the same edge: set wins
    wr(2'd0, 32'h5A5AFFFE);
    wr(2'd1, 32'hA5A5A5A0);
    step(1);
    wr(2'd1, 32'hA5A5A580);
    check("R7 req on collision", {31'd0, rst_req}, 32'h1);
    rd(2'd1, v); check("R7 set wins", {31'd0, v[5]}, 32'h1);
    wr(2'd1, 32'hA5A5A500);
    rd(2'd1, v); check("R7 later clear", {31'd0, v[5]}, 32'h0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule